// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits between four peripherals that want direct memory access and the processor that owns the system bus. When any enabled channel raises its request line, the block asks the processor for the bus with a hold request and waits for the hold acknowledge. It then picks one channel and drives that channel's active-low acknowledge. For each transfer it pulses either the active-low memory read strobe or the active-low memory write strobe, chosen by the channel's direction.

Each channel carries a 14-bit count of remaining transfers. The count is loaded through a small load port, and loading a nonzero count enables the channel. A single-cycle terminal count pulse marks the last transfer, and that transfer also disables the channel. Two static mode pins set the behaviour. One picks fixed or rotating priority. The other picks burst use of the bus, where the bus is held across back-to-back transfers, or cycle stealing, where the bus goes back to the processor after every transfer.

Top module: `dma_arbiter`

## Requirements
- R1: With rot_mode low, the lowest-numbered enabled requesting channel is served (channel 0 highest, channel 3 lowest).
- R2: With rot_mode high, the channel just served becomes lowest priority and the next channel up (modulo 4) becomes highest. After reset, channel 0 is highest.
- R3: After reset, hold_req is low, all acknowledges and both strobes are high, and term_cnt is low. hold_req rises one clock after an enabled request appears. No acknowledge or strobe goes active while hold_ack is low.
- R4: Each transfer lasts one clock. In that clock exactly one acknowledge line, the one for the granted channel, is low, and the grant does not change within the transfer.
- R5: A channel whose direction bit is 0 pulls mem_rd_n low during its transfers. A channel whose direction bit is 1 pulls mem_wr_n low. The two strobes are never low together.
- R6: Each transfer decrements the channel's count. The transfer made with a count of 1 raises term_cnt for that one clock and disables the channel, so later requests on that channel are ignored.
- R7: With burst_mode high, a channel that keeps requesting gets a transfer on every clock, without releasing hold_req, until its terminal count. After the terminal count, hold_req drops.
- R8: With burst_mode low, hold_req drops right after each transfer. It stays low until hold_ack has been seen low, plus one further clock for the processor's bus cycle.
- R9: If every enabled request disappears while the block waits for hold_ack, hold_req drops on the next clock.
- R10: A load writes ld_cnt and ld_dir into channel ld_ch. A nonzero count enables the channel. A count of zero leaves it disabled, and its requests are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load strobe for a channel's count and direction |
| ld_ch | input | 2 | Channel being loaded |
| ld_cnt | input | 14 | Number of transfers to perform |
| ld_dir | input | 1 | 0: read from memory, 1: write to memory |
| rot_mode | input | 1 | 1: rotating priority, 0: fixed priority |
| burst_mode | input | 1 | 1: burst, 0: cycle stealing |
| dreq | input | 4 | Peripheral request lines, active high |
| hold_ack | input | 1 | Bus granted by processor |
| hold_req | output | 1 | Bus request to processor |
| dack_n | output | 4 | Per-channel acknowledge, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| term_cnt | output | 1 | Terminal count pulse |

## Verification
The terminal count pulse and a transfer strobe fall in the same clock. In burst mode, that same clock is also where the decision to keep or release the bus is made. The bench loads a three-transfer count on a channel whose request stays high. It then checks term_cnt against the acknowledge and strobe on each of the three consecutive transfer clocks. It also checks that the next clock shows hold released, with no fourth transfer despite the live request. Priority is swept over all fifteen request patterns in both modes, with the rotating order predicted arithmetically from the last channel served.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
    localparam int NCH   = 4;
    localparam int CH_W  = $clog2(NCH);
    localparam int CNT_W = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_XFER,
        ST_GAP,
        ST_SLOT
    } arb_state_e;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
    } pick_t;

    // First active channel scanning upward from 'top', wrapping around.
    function automatic pick_t pick_from(logic [NCH-1:0] act, logic [CH_W-1:0] top);
        pick_t r;
        logic [CH_W-1:0] idx;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            idx = CH_W'((int'(top) + i) % NCH);
            if (act[idx]) begin
                r.valid = 1'b1;
                r.ch    = idx;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/dmaarb_prio.sv
module dmaarb_prio
    import dmaarb_pkg::*;
#(
    parameter int N   = NCH,
    localparam int W  = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] act,
    input  logic         rot_mode,
    input  logic         adv,
    input  logic [W-1:0] adv_ch,
    output pick_t        sel
);
    logic [W-1:0] top_q;

    always_ff @(posedge clk) begin
        if (rst)
            top_q <= '0;
        else if (adv)
            top_q <= rot_mode ? W'((int'(adv_ch) + 1) % N) : '0;
    end

    always_comb begin
        sel = pick_from(act, rot_mode ? top_q : '0);
    end

    // Fixed mode: no lower-numbered channel is active when one is chosen.
    p_fixed_order_r1: assert property (@(posedge clk) disable iff (rst)
        (!rot_mode && sel.valid) |-> ((act & ((N'(1) << sel.ch) - N'(1))) == '0));

    // Rotating mode: the chosen channel is always an active one.
    p_pick_active_r2: assert property (@(posedge clk) disable iff (rst)
        sel.valid |-> act[sel.ch]);
endmodule

// File: rtl/dmaarb_chan.sv
module dmaarb_chan
    import dmaarb_pkg::*;
#(
    parameter int N   = NCH,
    parameter int CW  = CNT_W,
    localparam int W  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  logic [W-1:0]  ld_ch,
    input  logic [CW-1:0] ld_cnt,
    input  logic          ld_dir,
    input  logic          dec,
    input  logic [W-1:0]  dec_ch,
    output logic [N-1:0]  en,
    output logic [N-1:0]  dir,
    output logic [N-1:0]  last
);
    for (genvar c = 0; c < N; c++) begin : g_ch
        logic [CW-1:0] cnt_q;
        logic          hit_dec;
        logic          hit_ld;

        assign hit_dec = dec && (dec_ch == W'(c));
        assign hit_ld  = ld_we && (ld_ch == W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q  <= '0;
                en[c]  <= 1'b0;
                dir[c] <= 1'b0;
            end else if (hit_dec) begin
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1))
                    en[c] <= 1'b0;
            end else if (hit_ld) begin
                cnt_q  <= ld_cnt;
                dir[c] <= ld_dir;
                en[c]  <= (ld_cnt != '0);
            end
        end

        assign last[c] = (cnt_q == CW'(1));

        p_tc_disables_r6: assert property (@(posedge clk) disable iff (rst)
            (hit_dec && last[c]) |=> !en[c]);

        p_zero_load_r10: assert property (@(posedge clk) disable iff (rst)
            (hit_ld && !hit_dec && ld_cnt == '0) |=> !en[c]);
    end
endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter
    import dmaarb_pkg::*;
#(
    parameter int N   = NCH,
    parameter int CW  = CNT_W,
    localparam int W  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_we,
    input  logic [W-1:0]  ld_ch,
    input  logic [CW-1:0] ld_cnt,
    input  logic          ld_dir,
    input  logic          rot_mode,
    input  logic          burst_mode,
    input  logic [N-1:0]  dreq,
    input  logic          hold_ack,
    output logic          hold_req,
    output logic [N-1:0]  dack_n,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic          term_cnt
);
    arb_state_e   state_q, state_d;
    logic [W-1:0] grant_q, grant_d;
    logic [N-1:0] en, dir, last, act;
    logic         xfer, keep;
    pick_t        sel;

    assign act  = dreq & en;
    assign xfer = (state_q == ST_XFER);

    dmaarb_chan #(.N(N), .CW(CW)) u_chan (
        .clk    (clk),
        .rst    (rst),
        .ld_we  (ld_we),
        .ld_ch  (ld_ch),
        .ld_cnt (ld_cnt),
        .ld_dir (ld_dir),
        .dec    (xfer),
        .dec_ch (grant_q),
        .en     (en),
        .dir    (dir),
        .last   (last)
    );

    dmaarb_prio #(.N(N)) u_prio (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .rot_mode (rot_mode),
        .adv      (xfer),
        .adv_ch   (grant_q),
        .sel      (sel)
    );

    assign keep = burst_mode && dreq[grant_q] && en[grant_q] && !last[grant_q];

    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        unique case (state_q)
            ST_IDLE: if (|act) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!(|act))
                    state_d = ST_IDLE;
                else if (hold_ack) begin
                    state_d = ST_XFER;
                    grant_d = sel.ch;
                end
            end
            ST_XFER: begin
                if (keep)
                    state_d = ST_XFER;
                else if (burst_mode)
                    state_d = ST_IDLE;
                else
                    state_d = ST_GAP;
            end
            ST_GAP:  if (!hold_ack) state_d = ST_SLOT;
            ST_SLOT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    always_comb begin
        hold_req = (state_q == ST_WAIT) || xfer;
        dack_n   = '1;
        if (xfer)
            dack_n[grant_q] = 1'b0;
        mem_rd_n = !(xfer && !dir[grant_q]);
        mem_wr_n = !(xfer && dir[grant_q]);
        term_cnt = xfer && last[grant_q];
    end

    p_ack_needs_bus_r3: assert property (@(posedge clk) disable iff (rst)
        (dack_n != '1) |-> (hold_req && hold_ack));

    p_ack_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dack_n));

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n));

    p_tc_in_xfer_r6: assert property (@(posedge clk) disable iff (rst)
        term_cnt |-> ((dack_n != '1) && (!mem_rd_n || !mem_wr_n)));

    p_burst_same_ch_r7: assert property (@(posedge clk) disable iff (rst)
        (xfer && keep) |=> (hold_req && dack_n == $past(dack_n)));

    p_steal_release_r8: assert property (@(posedge clk) disable iff (rst)
        (xfer && !burst_mode) |=> !hold_req);

    p_hold_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && act == '0) |=> !hold_req);
endmodule

// File: tb/sim_dma_arbiter.sv
module sim_dma_arbiter;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_we;
    logic [1:0]  ld_ch;
    logic [13:0] ld_cnt;
    logic        ld_dir;
    logic        rot_mode, burst_mode;
    logic [3:0]  dreq;
    logic        hold_ack;
    logic        hold_req;
    logic [3:0]  dack_n;
    logic        mem_rd_n, mem_wr_n, term_cnt;
    logic        auto_ack;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dma_arbiter u0 (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_ch(ld_ch), .ld_cnt(ld_cnt),
        .ld_dir(ld_dir), .rot_mode(rot_mode), .burst_mode(burst_mode),
        .dreq(dreq), .hold_ack(hold_ack), .hold_req(hold_req), .dack_n(dack_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .term_cnt(term_cnt)
    );

    // Processor model: grants the bus one half-cycle after it is asked.
    always @(negedge clk) hold_ack <= auto_ack ? hold_req : 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int ch, input int cnt, input bit d);
        @(negedge clk);
        ld_we = 1'b1; ld_ch = 2'(ch); ld_cnt = 14'(cnt); ld_dir = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Waits (sampling at negedges) for an active acknowledge; returns channel or -1.
    task automatic wait_ack(output int ch);
        ch = -1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (dack_n != 4'hF) begin
                for (int c = 0; c < 4; c++) if (!dack_n[c]) ch = c;
                return;
            end
        end
    endtask

    function automatic int first_from(input logic [3:0] p, input int top);
        for (int i = 0; i < 4; i++) if (p[(top + i) % 4]) return (top + i) % 4;
        return -1;
    endfunction

    initial begin
        int got, exp, top;
        ld_we = 0; ld_ch = 0; ld_cnt = 0; ld_dir = 0;
        rot_mode = 0; burst_mode = 0; dreq = 0; auto_ack = 1; hold_ack = 0;
        do_reset();
        @(negedge clk);
        // R3: reset state
        chk(!hold_req && dack_n == 4'hF && mem_rd_n && mem_wr_n && !term_cnt,
            "R3 reset state", {hold_req, dack_n, mem_rd_n, mem_wr_n, term_cnt}, 8'b0_1111_110);

        // R1: fixed priority over all request patterns
        for (int p = 1; p < 16; p++) begin
            for (int c = 0; c < 4; c++) load(c, 5, 1'b0);
            dreq = 4'(p);
            wait_ack(got);
            exp = first_from(4'(p), 0);
            chk(got == exp, "R1 fixed pick", got, exp);
            chk(!mem_rd_n && mem_wr_n, "R5 read strobe", {mem_rd_n, mem_wr_n}, 2'b01);
            dreq = 0;
            repeat (6) @(negedge clk);
        end

        // R2: rotating priority, predicted from last served channel
        do_reset();
        rot_mode = 1; top = 0;
        for (int p = 1; p < 16; p++) begin
            for (int c = 0; c < 4; c++) load(c, 5, 1'b0);
            dreq = 4'(p);
            wait_ack(got);
            exp = first_from(4'(p), top);
            chk(got == exp, "R2 rotate pick", got, exp);
            top = (exp + 1) % 4;
            dreq = 0;
            repeat (6) @(negedge clk);
        end
        // R2/R8: held requests on 1 and 3 alternate; bus released between
        for (int c = 0; c < 4; c++) load(c, 20, 1'b0);
        dreq = 4'b1010;
        for (int k = 0; k < 4; k++) begin
            wait_ack(got);
            exp = first_from(4'b1010, top);
            chk(got == exp, "R2 rotate sequence", got, exp);
            top = (exp + 1) % 4;
            @(negedge clk);
            chk(!hold_req && dack_n == 4'hF, "R8 release after transfer", hold_req, 0);
            @(negedge clk);
            chk(!hold_req, "R8 still released for cpu cycle", hold_req, 0);
        end
        dreq = 0;
        repeat (6) @(negedge clk);

        // R7/R6: burst of three on channel 2 with request held
        do_reset();
        burst_mode = 1;
        load(2, 3, 1'b0);
        dreq = 4'b0100;
        wait_ack(got);
        for (int k = 0; k < 3; k++) begin
            if (k > 0) @(negedge clk);
            chk(dack_n == 4'b1011 && hold_req, "R7 burst transfer", dack_n, 4'b1011);
            chk(term_cnt == (k == 2), "R6 terminal count timing", term_cnt, (k == 2));
            chk(!mem_rd_n, "R5 burst read strobe", mem_rd_n, 0);
        end
        @(negedge clk);
        chk(!hold_req && dack_n == 4'hF, "R7 hold dropped after tc", hold_req, 0);
        repeat (8) @(negedge clk);
        chk(!hold_req && dack_n == 4'hF, "R6 disabled channel ignored", hold_req, 0);
        dreq = 0;

        // R5/R6: write direction, single transfer, cycle steal
        burst_mode = 0;
        load(3, 1, 1'b1);
        dreq = 4'b1000;
        wait_ack(got);
        chk(got == 3, "R4 ack on channel 3", got, 3);
        chk(mem_rd_n && !mem_wr_n, "R5 write strobe", {mem_rd_n, mem_wr_n}, 2'b10);
        chk(term_cnt, "R6 tc with count one", term_cnt, 1);
        repeat (8) @(negedge clk);
        chk(!hold_req, "R6 channel 3 ignored after tc", hold_req, 0);
        dreq = 0;

        // R10: zero count leaves channel disabled
        load(1, 0, 1'b0);
        dreq = 4'b0010;
        repeat (6) @(negedge clk);
        chk(!hold_req && dack_n == 4'hF, "R10 zero load ignored", hold_req, 0);
        dreq = 0;

        // R3/R9: no grant without hold_ack; hold drops when request leaves
        auto_ack = 0;
        load(0, 4, 1'b0);
        dreq = 4'b0001;
        @(negedge clk);
        chk(hold_req, "R3 hold raised", hold_req, 1);
        repeat (5) @(negedge clk);
        chk(hold_req && dack_n == 4'hF && mem_rd_n, "R3 no ack without hold_ack", dack_n, 4'hF);
        dreq = 0;
        @(negedge clk);
        chk(!hold_req, "R9 hold dropped", hold_req, 1'b0);
        auto_ack = 1;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule